// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block holds the burst configuration of a synchronous DRAM and turns a single starting column into the column address for each beat of a burst. A controller writes a 12-bit mode word with a one-cycle load strobe. The block decodes and keeps the burst length, the wrap order, the CAS latency and the write-burst policy. When the controller pulses the burst start with a column and a read/write flag, the block presents one column address per accepted beat.

The addresses stay inside the aligned block of the burst length. The order is either a modulo count upward or the start address XORed with a beat counter. A full-page burst walks all columns of the row, wraps from the top column to zero, and runs until a stop.

The column output is a valid/ready stream. A beat is consumed in a cycle where `col_valid` and `col_ready` are both high. While `col_ready` is low, the address and valid hold and the burst does not advance. `col_valid` never waits on `col_ready`. The CAS latency and the single-write flag are plain status outputs.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `mode_err` are 0. `cas_lat` reads 2, `write_single` reads 0, and the burst length is 1.
- R2: On a load that is accepted, the new values are visible on the cycle after the strobe. `cas_lat` becomes mode bits 6:4 (001=1, 010=2, 011=3), and `write_single` becomes bit 9. Bits 2:0 give the length (000=1, 001=2, 010=4, 011=8, 111=full page), and bit 3 gives the order (0 sequential, 1 interleaved).
- R3: Some loads are rejected. These are a length code of 100, 101 or 110; code 111 with bit 3 set; a latency code of 000 or 100 to 111; and nonzero bits 8:7 or 11:10. A rejected load sets `mode_err` and leaves every setting unchanged. An accepted load clears `mode_err`.
- R4: In sequential order with length N of 2, 4 or 8, beat i has the low log2(N) bits equal to (start+i) mod N. The upper column bits equal those of the start.
- R5: In interleaved order with length N of 2, 4 or 8, beat i has the low bits equal to start XOR i. The upper bits are unchanged.
- R6: With length 1, a burst gives exactly one beat at the start column, whatever bit 3 holds.
- R7: A full-page burst counts upward from the start and wraps from 255 to 0. It keeps going until stopped and never raises `col_last`.
- R8: When `write_single` is 1, a burst started with `burst_write`=1 gives one beat. A read burst still uses the programmed length.
- R9: With `col_ready` held high, `col_valid` stays high for exactly the burst length in cycles. The first beat appears the cycle after the start. `col_last` is high only with the final beat.
- R10: While `col_valid` is high and `col_ready` is low, `col_addr` and `col_valid` hold.
- R11: `burst_stop` during a burst drops `col_valid` on the next clock. A `burst_start` in the same cycle wins over it.
- R12: A `burst_start` during a burst abandons it. The next cycle shows beat 0 of the new start column.
- R13: The settings are captured at burst start. A mode load during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 12 | Mode word |
| mode_err | output | 1 | Last load was rejected |
| cas_lat | output | 2 | Decoded CAS latency (1 to 3) |
| write_single | output | 1 | Writes use one location |
| burst_start | input | 1 | Start a burst |
| burst_write | input | 1 | Burst is a write (1) or a read (0) |
| start_col | input | 8 | Starting column |
| burst_stop | input | 1 | End the running burst |
| col_valid | output | 1 | Column stream valid |
| col_ready | input | 1 | Column stream ready |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |

## Verification
A beat counter that is off by one shows at the ports as the wrong low column bits on the second beat. It also shows as a valid window that is one cycle too long or too short, caught at the first burst end. A mask or base register that is captured wrongly shows as changed upper column bits within one beat, or as a wrap past the block edge. A mode register that is updated on a rejected load shows as a changed latency or burst length on the very next cycle and burst. A lost stop or hold state shows as the address moving while ready is low, or as valid still high one cycle after a stop.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  localparam int MODE_W = 12;
  localparam logic [2:0] LEN_ONE  = 3'd0;
  localparam logic [2:0] LEN_PAGE = 3'd7;

  typedef struct packed {
    logic [2:0] len_code;
    logic       interleave;
    logic [1:0] cas;
    logic       write_single;
  } mode_cfg_t;
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_col_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_cfg_t         cfg,
  output logic              err
);
  logic len_ok, cas_ok, op_ok, bad;

  always_comb begin
    len_ok = (word[2:0] <= 3'd3) || (word[2:0] == LEN_PAGE && !word[3]);
    cas_ok = (word[6:4] >= 3'd1) && (word[6:4] <= 3'd3);
    op_ok  = (word[8:7] == 2'b00) && (word[11:10] == 2'b00);
    bad    = !(len_ok && cas_ok && op_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '{len_code: LEN_ONE, interleave: 1'b0, cas: 2'd2, write_single: 1'b0};
      err <= 1'b0;
    end else if (load) begin
      err <= bad;
      if (!bad) begin
        cfg.len_code     <= word[2:0];
        cfg.interleave   <= word[3];
        cfg.cas          <= word[5:4];
        cfg.write_single <= word[9];
      end
    end
  end

  assert_reserved_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load && bad |=> err && $stable(cfg));

  assert_load_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load && !bad |=> !err && cfg.cas == $past(word[5:4]) &&
                     cfg.write_single == $past(word[9]));
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_cfg_t        cfg,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  logic             ready,
  output logic             valid,
  output logic [COL_W-1:0] addr,
  output logic             last
);
  logic [2:0]       eff_code;
  logic [COL_W-1:0] new_len_m1, new_mask;
  logic             active, full, inter;
  logic [COL_W-1:0] base, cnt, len_m1, mask;

  always_comb begin
    eff_code = (is_write && cfg.write_single) ? LEN_ONE : cfg.len_code;
    case (eff_code)
      3'd1:    new_len_m1 = COL_W'(1);
      3'd2:    new_len_m1 = COL_W'(3);
      3'd3:    new_len_m1 = COL_W'(7);
      default: new_len_m1 = '0;
    endcase
    new_mask = (eff_code == LEN_PAGE) ? '1 : new_len_m1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      full   <= 1'b0;
      inter  <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      len_m1 <= '0;
      mask   <= '0;
    end else if (start) begin
      active <= 1'b1;
      full   <= (eff_code == LEN_PAGE);
      inter  <= cfg.interleave && (eff_code != LEN_PAGE);
      base   <= start_col;
      cnt    <= '0;
      len_m1 <= new_len_m1;
      mask   <= new_mask;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && ready) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (inter) addr = (base & ~mask) | ((base ^ cnt) & mask);
    else       addr = (base & ~mask) | ((base + cnt) & mask);
    valid = active;
    last  = active && !full && (cnt == len_m1);
  end

  assert_last_in_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !start && !stop |=> valid && $stable(addr));

  assert_stop_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !valid);

  assert_restart_col_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid && addr == $past(start_col));

  assert_stay_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !last && !start && !stop |=>
      valid && (((addr ^ $past(addr)) & ~mask) == '0));
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  output logic              mode_err,
  output logic [1:0]        cas_lat,
  output logic              write_single,
  input  logic              burst_start,
  input  logic              burst_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic              burst_stop,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last
);
  mode_cfg_t cfg;

  sdram_mode_reg u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mode_load),
    .word (mode_word),
    .cfg  (cfg),
    .err  (mode_err)
  );

  sdram_col_gen #(.COL_W(COL_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .start    (burst_start),
    .is_write (burst_write),
    .start_col(start_col),
    .stop     (burst_stop),
    .ready    (col_ready),
    .valid    (col_valid),
    .addr     (col_addr),
    .last     (col_last)
  );

  assign cas_lat      = cfg.cas;
  assign write_single = cfg.write_single;
endmodule

// File: tb/sdram_col_seq_test.sv
`timescale 1ns/1ps
module sdram_col_seq_test;
  logic clk = 0, rst_n = 0;
  logic mode_load = 0, burst_start = 0, burst_write = 0, burst_stop = 0, col_ready = 1;
  logic [11:0] mode_word = 0;
  logic [7:0] start_col = 0;
  logic mode_err, write_single, col_valid, col_last;
  logic [1:0] cas_lat;
  logic [7:0] col_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_col_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .mode_err(mode_err), .cas_lat(cas_lat), .write_single(write_single),
    .burst_start(burst_start), .burst_write(burst_write), .start_col(start_col),
    .burst_stop(burst_stop), .col_valid(col_valid), .col_ready(col_ready),
    .col_addr(col_addr), .col_last(col_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] mw(input bit wb, input logic [2:0] cl,
                                     input bit bt, input logic [2:0] bl);
    return {2'b00, wb, 2'b00, cl, bt, bl};
  endfunction

  function automatic int exp_col(input int st, input int i, input int len, input bit il);
    int m;
    if (len == 256) return (st + i) % 256;
    m = len - 1;
    if (il) return (st & ~m) | ((st ^ i) & m);
    return (st & ~m) | ((st + i) & m);
  endfunction

  // at a negedge: apply a mode word, return at the following negedge
  task automatic load(input logic [11:0] w);
    mode_word = w; mode_load = 1;
    @(negedge clk);
    mode_load = 0;
  endtask

  // caller is at a negedge; checks nb beats, then optionally the idle after
  task automatic burst(input string req, input int st, input bit wr, input int len,
                       input bit il, input int nb, input bit chk_end);
    start_col = st[7:0]; burst_write = wr; burst_start = 1;
    @(negedge clk);
    burst_start = 0;
    for (int i = 0; i < nb; i++) begin
      if (i > 0) @(negedge clk);
      chk(col_valid === 1'b1, req, col_valid, 1);
      chk(col_addr == exp_col(st, i, len, il), req, col_addr, exp_col(st, i, len, il));
      chk(col_last === (len != 256 && i == len - 1), req, col_last,
          (len != 256 && i == len - 1));
    end
    if (chk_end) begin
      @(negedge clk);
      chk(col_valid === 1'b0, req, col_valid, 0);
    end
  endtask

  task automatic t_reset;
    chk(col_valid === 0 && col_last === 0, "R1", col_valid, 0);
    chk(mode_err === 0, "R1", mode_err, 0);
    chk(cas_lat == 2, "R1", cas_lat, 2);
    chk(write_single === 0, "R1", write_single, 0);
    burst("R1", 8'h33, 0, 1, 0, 1, 1);
  endtask

  task automatic t_orders;
    load(mw(0, 3'd3, 0, 3'd3));
    chk(cas_lat == 3 && mode_err === 0, "R2", cas_lat, 3);
    burst("R4", 8'h45, 0, 8, 0, 8, 1);
    burst("R9", 8'h9B, 0, 8, 0, 8, 1);
    load(mw(0, 3'd1, 1, 3'd3));
    chk(cas_lat == 1, "R2", cas_lat, 1);
    burst("R5", 8'h45, 0, 8, 1, 8, 1);
    load(mw(0, 3'd2, 0, 3'd2));
    burst("R4", 8'h0E, 0, 4, 0, 4, 1);
    load(mw(0, 3'd2, 1, 3'd2));
    burst("R5", 8'hC9, 0, 4, 1, 4, 1);
    load(mw(0, 3'd2, 1, 3'd1));
    burst("R5", 8'h33, 0, 2, 1, 2, 1);
    load(mw(0, 3'd2, 1, 3'd0));
    burst("R6", 8'h77, 0, 1, 0, 1, 1);
  endtask

  task automatic t_reserved;
    load(mw(0, 3'd2, 0, 3'd2));
    chk(mode_err === 0, "R3", mode_err, 0);
    load(mw(0, 3'd3, 0, 3'd4));
    chk(mode_err === 1 && cas_lat == 2, "R3", cas_lat, 2);
    load(mw(0, 3'd3, 1, 3'd7));
    chk(mode_err === 1 && cas_lat == 2, "R3", cas_lat, 2);
    load(mw(0, 3'd0, 0, 3'd3));
    chk(mode_err === 1 && cas_lat == 2, "R3", cas_lat, 2);
    load(mw(0, 3'd3, 0, 3'd3) | 12'h080);
    chk(mode_err === 1 && cas_lat == 2, "R3", cas_lat, 2);
    load(mw(1, 3'd3, 0, 3'd3) | 12'h400);
    chk(mode_err === 1 && write_single === 0, "R3", write_single, 0);
    burst("R3", 8'h12, 0, 4, 0, 4, 1);
    load(mw(0, 3'd3, 0, 3'd1));
    chk(mode_err === 0 && cas_lat == 3, "R3", mode_err, 0);
  endtask

  task automatic t_page;
    load(mw(0, 3'd2, 0, 3'd7));
    burst("R7", 8'hFC, 0, 256, 0, 260, 0);
    burst_stop = 1;
    @(negedge clk);
    burst_stop = 0;
    chk(col_valid === 0, "R11", col_valid, 0);
  endtask

  task automatic t_write_single;
    load(mw(1, 3'd2, 0, 3'd2));
    chk(write_single === 1, "R2", write_single, 1);
    burst("R8", 8'h2A, 1, 1, 0, 1, 1);
    burst("R8", 8'h2A, 0, 4, 0, 4, 1);
  endtask

  task automatic t_stall;
    load(mw(0, 3'd2, 0, 3'd2));
    burst("R10", 8'h20, 0, 4, 0, 2, 0);
    col_ready = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(col_valid === 1 && col_addr == 8'h21, "R10", col_addr, 8'h21);
    end
    col_ready = 1;
    @(negedge clk);
    chk(col_addr == 8'h22, "R10", col_addr, 8'h22);
    @(negedge clk);
    chk(col_addr == 8'h23 && col_last === 1, "R10", col_addr, 8'h23);
    @(negedge clk);
    chk(col_valid === 0, "R10", col_valid, 0);
  endtask

  task automatic t_restart;
    load(mw(0, 3'd2, 0, 3'd3));
    burst("R12", 8'h10, 0, 8, 0, 3, 0);
    burst("R12", 8'h35, 0, 8, 0, 8, 1);
    burst("R11", 8'h40, 0, 8, 0, 2, 0);
    burst_stop = 1;
    burst("R11", 8'h5C, 0, 8, 0, 1, 0);
    burst_stop = 0;
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      chk(col_addr == exp_col(8'h5C, i, 8, 0), "R11", col_addr, exp_col(8'h5C, i, 8, 0));
    end
    @(negedge clk);
    chk(col_valid === 0, "R11", col_valid, 0);
  endtask

  task automatic t_load_mid;
    load(mw(0, 3'd2, 1, 3'd3));
    start_col = 8'h03; burst_write = 0; burst_start = 1;
    @(negedge clk);
    burst_start = 0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      mode_load = (i == 1);
      mode_word = mw(0, 3'd2, 0, 3'd1);
      chk(col_valid === 1 && col_addr == exp_col(3, i, 8, 1), "R13", col_addr,
          exp_col(3, i, 8, 1));
    end
    mode_load = 0;
    @(negedge clk);
    chk(col_valid === 0, "R13", col_valid, 0);
    burst("R13", 8'h03, 0, 2, 0, 2, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_orders;
    t_reserved;
    t_page;
    t_write_single;
    t_stall;
    t_restart;
    t_load_mid;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule